// File: doc/BRIEF.md
# Backplane Slave Cycle Controller

This block runs the slave side of a 24-bit-address, 16-bit-data backplane cycle from one local system clock. The backplane inputs are asynchronous: the data strobe, write line, system reset, address and geographic code. The block brings all of them into the clock domain and waits until the strobe has been seen low on two samples in a row. At that point it registers whether the cycle belongs to this card. A card is selected when the seven upper address bits equal its geographic code. Four of those code bits come from the slot wiring and three from on-card jumpers.

For a selected cycle, the block raises an internal ownership flag and sets the data-path direction: high for a read, low for a write. It enables the data path, and after a fixed number of clocks it requests the acknowledge. Targets on the internal bus therefore see a synchronous bus with a fixed access window.

The cycle ends when the strobe returns high or the backplane reset is asserted. A combinational gate models an external safety stage. It lets the acknowledge and the backplane data drive through only while the supplies, configuration, running-OK and an enable jumper are all good. The receiver and translator controls are held at fixed levels.

Top module: `vme_slave_ctl`

## Requirements
- R1: While `rst` is high, and right after it, `mine_o` is 0, `ack_n_o` is 1, both output enables are 1, both direction outputs are 0 and `run_ok_n_o` is 1.
- R2: The card is selected when address bits 23..17 equal `geo_i`. For a selected cycle, `mine_o` is 1 from the fourth clock edge after the strobe is first sampled low. For any other address, `mine_o` stays 0.
- R3: A strobe low pulse that is seen on only one clock edge starts no cycle.
- R4: The match decision is captured once per strobe-low period. Address changes after capture do not alter `mine_o`.
- R5: `ack_n_o` goes low ACK_DLY clocks after `mine_o` rises, provided the gate allows it. It is never low while `mine_o` is 0.
- R6: `mine_o` and the acknowledge release on the third edge after the strobe is first sampled high, or after `sysrst_n_i` is first sampled low.
- R7: `dir_bp_o` and `dir_int_o` are always equal. Both are 1 in a selected read (`write_n_i`=1) and 0 in a selected write or when idle.
- R8: `int_oe_n_o` is 0 exactly while `mine_o` is 1.
- R9: `ack_n_o` and `bp_oe_n_o` stay 1 unless `supplies_ok_i`, `cfg_done_i` and `jumper_i` are 1 and `run_ok_n_o` is 0.
- R10: `run_ok_n_o` and `ac_oe_n_o` go low on the third edge after `cfg_done_i` is sampled high, and go high on the third edge after it is sampled low.
- R11: `adr_le_o` and `ctl_le_o` are always 0, `rcv_oe_n_o` is always 1, and `ac_dir_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_n_i | input | 1 | Backplane data strobe, active low, asynchronous |
| write_n_i | input | 1 | Backplane write line, low = write |
| sysrst_n_i | input | 1 | Backplane system reset, active low |
| addr_i | input | ADDR_W | Address lines 23..1 |
| geo_i | input | GEO_W | Geographic code (slot plus jumpers) |
| supplies_ok_i | input | 1 | All supplies good |
| cfg_done_i | input | 1 | Device configured |
| jumper_i | input | 1 | Backplane enable jumper fitted |
| mine_o | output | 1 | Current cycle targets this card |
| ack_n_o | output | 1 | Gated acknowledge, active low |
| dir_bp_o | output | 1 | Transceiver direction, 1 = read |
| dir_int_o | output | 1 | Translator direction, 1 = read |
| bp_oe_n_o | output | 1 | Gated transceiver enable, active low |
| int_oe_n_o | output | 1 | Translator enable, active low |
| run_ok_n_o | output | 1 | Running-OK status, active low |
| adr_le_o | output | 1 | Address receiver latch enable |
| ctl_le_o | output | 1 | Control receiver latch enable |
| rcv_oe_n_o | output | 1 | Receiver output enable |
| ac_dir_o | output | 1 | Address/control translator direction |
| ac_oe_n_o | output | 1 | Address/control translator enable, active low |

## Verification
The bench builds the block with ACK_DLY set to 3 and two synchronizer stages. With these values the acknowledge lands on the seventh edge after the strobe is sampled low. A hold of twelve clocks then leaves room to move the address after capture, to drop the backplane reset after the acknowledge, and to see release before the next cycle. The short delay also keeps each gated-off scenario (jumper, supplies, configuration) within a few cycles. That allows every gate input to be checked on its own.

// File: rtl/vslv_pkg.sv
package vslv_pkg;
  // Synchronized backplane control lines, all low-active.
  typedef struct packed {
    logic sysrst_n;
    logic write_n;
    logic strobe_n;
  } bus_ctl_t;

  localparam bus_ctl_t CTL_IDLE = '{sysrst_n: 1'b1, write_n: 1'b1, strobe_n: 1'b1};
endpackage

// File: rtl/vslv_sync.sv
module vslv_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) stg[0] <= rst ? RST_VAL : d;
    end else begin : g_next
      always_ff @(posedge clk) stg[i] <= rst ? RST_VAL : stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/vslv_decode.sv
module vslv_decode #(
  parameter int GEO_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GEO_W-1:0] addr_hi,
  input  logic [GEO_W-1:0] geo,
  output logic             match_q
);
  // Registered compare: decode skew never reaches the cycle logic.
  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= (addr_hi == geo);
  end
endmodule

// File: rtl/vslv_cycle.sv
module vslv_cycle #(
  parameter int ACK_DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n_s,
  input  logic write_n_s,
  input  logic sysrst_n_s,
  input  logic match,
  output logic mine_q,
  output logic rd_q,
  output logic ack_q
);
  localparam int CNT_W = $clog2(ACK_DLY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DLY - 1);

  logic             strb_d;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             teardown;
  logic             confirm;

  assign teardown = strobe_n_s | ~sysrst_n_s;
  assign confirm  = ~strobe_n_s & ~strb_d;

  always_ff @(posedge clk) begin
    if (rst) strb_d <= 1'b1;
    else     strb_d <= strobe_n_s;
  end

  always_ff @(posedge clk) begin
    if (rst || teardown) begin
      mine_q <= 1'b0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
      ack_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (confirm && !done_q) begin
        done_q <= 1'b1;
        mine_q <= match;
        rd_q   <= match & write_n_s;
      end
      if (mine_q && !ack_q) begin
        cnt_q <= cnt_q + 1'b1;
        ack_q <= (cnt_q == CNT_LAST);
      end
    end
  end
endmodule

// File: rtl/vslv_gate.sv
module vslv_gate (
  input  logic supplies_ok,
  input  logic cfg_done,
  input  logic run_ok_n,
  input  logic jumper,
  input  logic ack_req,
  input  logic drive_req,
  output logic ack_n,
  output logic drive_n
);
  logic allow;
  assign allow   = supplies_ok & cfg_done & ~run_ok_n & jumper;
  assign ack_n   = ~(ack_req & allow);
  assign drive_n = ~(drive_req & allow);
endmodule

// File: rtl/vme_slave_ctl.sv
module vme_slave_ctl
  import vslv_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int GEO_W = 7,
  parameter int ACK_DLY = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_n_i,
  input  logic              write_n_i,
  input  logic              sysrst_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [GEO_W-1:0]  geo_i,
  input  logic              supplies_ok_i,
  input  logic              cfg_done_i,
  input  logic              jumper_i,
  output logic              mine_o,
  output logic              ack_n_o,
  output logic              dir_bp_o,
  output logic              dir_int_o,
  output logic              bp_oe_n_o,
  output logic              int_oe_n_o,
  output logic              run_ok_n_o,
  output logic              adr_le_o,
  output logic              ctl_le_o,
  output logic              rcv_oe_n_o,
  output logic              ac_dir_o,
  output logic              ac_oe_n_o
);
  localparam int BUS_W = ADDR_W + GEO_W;

  bus_ctl_t          ctl_raw, ctl_s;
  logic [BUS_W-1:0]  bus_s;
  logic [ADDR_W-1:0] addr_s;
  logic [GEO_W-1:0]  geo_s;
  logic              cfg_s;
  logic              match;
  logic              mine_q, rd_q, ack_q;
  logic              run_ok_n_q;

  assign ctl_raw = '{sysrst_n: sysrst_n_i, write_n: write_n_i, strobe_n: strobe_n_i};

  vslv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s));

  vslv_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst(rst), .d({addr_i, geo_i}), .q(bus_s));

  vslv_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cfg (
    .clk(clk), .rst(rst), .d(cfg_done_i), .q(cfg_s));

  assign {addr_s, geo_s} = bus_s;

  vslv_decode #(.GEO_W(GEO_W)) u_decode (
    .clk(clk), .rst(rst),
    .addr_hi(addr_s[ADDR_W-1 -: GEO_W]), .geo(geo_s), .match_q(match));

  vslv_cycle #(.ACK_DLY(ACK_DLY)) u_cycle (
    .clk(clk), .rst(rst),
    .strobe_n_s(ctl_s.strobe_n), .write_n_s(ctl_s.write_n), .sysrst_n_s(ctl_s.sysrst_n),
    .match(match), .mine_q(mine_q), .rd_q(rd_q), .ack_q(ack_q));

  always_ff @(posedge clk) begin
    if (rst) run_ok_n_q <= 1'b1;
    else     run_ok_n_q <= ~cfg_s;
  end

  // Model of the hardwired safety stage outside the device.
  vslv_gate u_gate (
    .supplies_ok(supplies_ok_i), .cfg_done(cfg_done_i), .run_ok_n(run_ok_n_q),
    .jumper(jumper_i), .ack_req(ack_q), .drive_req(mine_q),
    .ack_n(ack_n_o), .drive_n(bp_oe_n_o));

  assign mine_o     = mine_q;
  assign dir_bp_o   = rd_q;
  assign dir_int_o  = rd_q;
  assign int_oe_n_o = ~mine_q;
  assign run_ok_n_o = run_ok_n_q;
  assign ac_oe_n_o  = run_ok_n_q;
  assign adr_le_o   = 1'b0;
  assign ctl_le_o   = 1'b0;
  assign rcv_oe_n_o = 1'b1;
  assign ac_dir_o   = 1'b0;
endmodule

// File: rtl/vslv_chk.sv
module vslv_chk (
  input logic clk,
  input logic rst,
  input logic strobe_n_i,
  input logic sysrst_n_i,
  input logic supplies_ok_i,
  input logic cfg_done_i,
  input logic jumper_i,
  input logic mine_o,
  input logic ack_n_o,
  input logic dir_bp_o,
  input logic dir_int_o,
  input logic bp_oe_n_o,
  input logic run_ok_n_o
);
  // Windows below assume two synchronizer stages.

  a_r3_start_needs_two_lows: assert property (@(posedge clk) disable iff (rst)
    $rose(mine_o) |-> (!$past(strobe_n_i, 3) && !$past(strobe_n_i, 4)));

  a_r5_ack_inside_cycle: assert property (@(posedge clk) disable iff (rst)
    !ack_n_o |-> mine_o);

  a_r5_ack_after_mine: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n_o) |-> $past(mine_o));

  a_r6_strobe_release: assert property (@(posedge clk) disable iff (rst)
    strobe_n_i |-> ##3 (!mine_o && ack_n_o));

  a_r6_sysrst_release: assert property (@(posedge clk) disable iff (rst)
    !sysrst_n_i |-> ##3 (!mine_o && ack_n_o));

  a_r7_dir_match: assert property (@(posedge clk) disable iff (rst)
    dir_bp_o == dir_int_o);

  a_r7_idle_dir: assert property (@(posedge clk) disable iff (rst)
    !mine_o |-> !dir_bp_o);

  a_r9_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    (!supplies_ok_i || !cfg_done_i || !jumper_i || run_ok_n_o) |-> (ack_n_o && bp_oe_n_o));

  a_r10_cfg_loss: assert property (@(posedge clk) disable iff (rst)
    !cfg_done_i |-> ##3 run_ok_n_o);
endmodule

bind vme_slave_ctl vslv_chk u_chk (
  .clk(clk), .rst(rst), .strobe_n_i(strobe_n_i), .sysrst_n_i(sysrst_n_i),
  .supplies_ok_i(supplies_ok_i), .cfg_done_i(cfg_done_i), .jumper_i(jumper_i),
  .mine_o(mine_o), .ack_n_o(ack_n_o), .dir_bp_o(dir_bp_o), .dir_int_o(dir_int_o),
  .bp_oe_n_o(bp_oe_n_o), .run_ok_n_o(run_ok_n_o));

// File: tb/vme_slave_ctl_test.sv
`timescale 1ns/1ps
module vme_slave_ctl_test;
  localparam int D = 3;
  localparam logic [6:0] GEO = 7'h2D;
  localparam logic [15:0] LO = 16'hA5C3;

  typedef enum int {S_MINE, S_ACK, S_DIR, S_IOE, S_BOE, S_RUN, S_AOE} sig_e;
  typedef struct {
    int    cyc;
    sig_e  sig;
    logic  val;
    string tag;
  } exp_t;

  logic clk = 0, rst = 1;
  logic strobe_n = 1, write_n = 1, sysrst_n = 1;
  logic [22:0] addr = '0;
  logic sup = 1, cfg = 1, jmp = 1;
  logic mine, ack_n, dir_bp, dir_int, bp_oe_n, int_oe_n, run_ok_n;
  logic adr_le, ctl_le, rcv_oe_n, ac_dir, ac_oe_n;

  int cyc = 0, checks = 0, errors = 0;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vme_slave_ctl #(.ACK_DLY(D)) uut (
    .clk(clk), .rst(rst), .strobe_n_i(strobe_n), .write_n_i(write_n), .sysrst_n_i(sysrst_n),
    .addr_i(addr), .geo_i(GEO), .supplies_ok_i(sup), .cfg_done_i(cfg), .jumper_i(jmp),
    .mine_o(mine), .ack_n_o(ack_n), .dir_bp_o(dir_bp), .dir_int_o(dir_int),
    .bp_oe_n_o(bp_oe_n), .int_oe_n_o(int_oe_n), .run_ok_n_o(run_ok_n),
    .adr_le_o(adr_le), .ctl_le_o(ctl_le), .rcv_oe_n_o(rcv_oe_n), .ac_dir_o(ac_dir),
    .ac_oe_n_o(ac_oe_n));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic peek(input sig_e s);
    case (s)
      S_MINE:  return mine;
      S_ACK:   return ack_n;
      S_DIR:   return dir_bp;
      S_IOE:   return int_oe_n;
      S_BOE:   return bp_oe_n;
      S_RUN:   return run_ok_n;
      default: return ac_oe_n;
    endcase
  endfunction

  task automatic push(input int c, input sig_e s, input logic v, input string tag);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare every expected item due at this cycle.
  always @(negedge clk) begin
    int i;
    i = 0;
    while (i < q.size()) begin
      if (q[i].cyc == cyc) begin
        chk(q[i].tag, peek(q[i].sig), q[i].val);
        if (q[i].sig == S_DIR) chk("R7 pair", dir_int, dir_bp);
        q.delete(i);
      end else if (q[i].cyc < cyc) begin
        chk({q[i].tag, " missed"}, 1'b0, 1'b1);
        q.delete(i);
      end else begin
        i++;
      end
    end
  end

  // Driver: full cycle with an address switch after capture.
  task automatic do_cycle(input logic [6:0] hi, input logic [6:0] alt, input logic rd,
                          input logic gate_ok, input int hold);
    int n;
    logic m;
    @(negedge clk);
    addr = {hi, LO};
    write_n = rd;
    @(negedge clk);
    n = cyc;
    strobe_n = 0;
    m = (hi == GEO);
    push(n + 3, S_MINE, 1'b0, "R2");
    push(n + 4, S_MINE, m, "R2");
    push(n + 4, S_DIR, m & rd, "R7");
    push(n + 4, S_IOE, !m, "R8");
    push(n + 4, S_BOE, !(m & gate_ok), "R9");
    push(n + 3 + D, S_ACK, 1'b1, "R5");
    push(n + 4 + D, S_ACK, !(m & gate_ok), "R5");
    push(n + 8, S_MINE, m, "R4");
    push(n + hold + 2, S_MINE, m, "R6");
    push(n + hold + 3, S_MINE, 1'b0, "R6");
    push(n + hold + 3, S_ACK, 1'b1, "R6");
    push(n + hold + 3, S_DIR, 1'b0, "R7");
    push(n + hold + 3, S_IOE, 1'b1, "R8");
    repeat (5) @(negedge clk);
    addr = {alt, LO};
    repeat (hold - 5) @(negedge clk);
    strobe_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic glitch();
    int n;
    @(negedge clk);
    addr = {GEO, LO};
    @(negedge clk);
    n = cyc;
    strobe_n = 0;
    @(negedge clk);
    strobe_n = 1;
    push(n + 4, S_MINE, 1'b0, "R3");
    push(n + 5, S_MINE, 1'b0, "R3");
    push(n + 4 + D, S_ACK, 1'b1, "R3");
    repeat (D + 8) @(negedge clk);
  endtask

  task automatic sysrst_abort();
    int n;
    @(negedge clk);
    addr = {GEO, LO};
    write_n = 1;
    @(negedge clk);
    n = cyc;
    strobe_n = 0;
    push(n + 4 + D, S_ACK, 1'b0, "R6");
    push(n + 10, S_MINE, 1'b1, "R6");
    push(n + 11, S_MINE, 1'b0, "R6");
    push(n + 11, S_ACK, 1'b1, "R6");
    push(n + 11, S_BOE, 1'b1, "R6");
    repeat (8) @(negedge clk);
    sysrst_n = 0;
    repeat (4) @(negedge clk);
    sysrst_n = 1;
    strobe_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cfg_drop();
    int k;
    @(negedge clk);
    k = cyc;
    cfg = 0;
    push(k + 2, S_RUN, 1'b0, "R10");
    push(k + 3, S_RUN, 1'b1, "R10");
    push(k + 3, S_AOE, 1'b1, "R10");
    repeat (6) @(negedge clk);
    do_cycle(GEO, GEO, 1'b1, 1'b0, 12);
    @(negedge clk);
    k = cyc;
    cfg = 1;
    push(k + 3, S_RUN, 1'b0, "R10");
    push(k + 3, S_AOE, 1'b0, "R10");
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 mine", mine, 1'b0);
    chk("R1 ack", ack_n, 1'b1);
    chk("R1 boe", bp_oe_n, 1'b1);
    chk("R1 ioe", int_oe_n, 1'b1);
    chk("R1 dir", dir_bp, 1'b0);
    chk("R1 run", run_ok_n, 1'b1);
    // R11 fixed controls
    chk("R11 adr_le", adr_le, 1'b0);
    chk("R11 ctl_le", ctl_le, 1'b0);
    chk("R11 rcv_oe", rcv_oe_n, 1'b1);
    chk("R11 ac_dir", ac_dir, 1'b0);
    @(negedge clk);
    r = cyc;
    rst = 0;
    push(r + 2, S_RUN, 1'b1, "R10");
    push(r + 3, S_RUN, 1'b0, "R10");
    push(r + 3, S_AOE, 1'b0, "R10");
    repeat (6) @(negedge clk);

    do_cycle(GEO, 7'h11, 1'b1, 1'b1, 12);   // matching read, address moves away
    do_cycle(GEO, GEO, 1'b0, 1'b1, 12);     // matching write
    do_cycle(7'h12, GEO, 1'b1, 1'b1, 12);   // non-match, address moves onto card
    do_cycle(7'h6D, 7'h6D, 1'b0, 1'b1, 12); // single-bit miss
    glitch();
    sysrst_abort();

    jmp = 0;
    do_cycle(GEO, GEO, 1'b1, 1'b0, 12);     // R9 jumper
    jmp = 1;
    sup = 0;
    do_cycle(GEO, GEO, 1'b0, 1'b0, 12);     // R9 supplies
    sup = 1;
    cfg_drop();                             // R9 config, R10 running-OK
    do_cycle(GEO, GEO, 1'b1, 1'b1, 12);     // back to normal

    chk("R11 adr_le end", adr_le, 1'b0);
    chk("R11 rcv_oe end", rcv_oe_n, 1'b1);
    repeat (4) @(negedge clk);
    if (q.size() != 0) chk("scoreboard drained", 1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule